// File: doc/BRIEF.md
# Move-and-Loop Condition Branch Unit

This unit performs the loop-control decision for a 32-bit instruction that loads a word through a post-incremented base register and then conditionally jumps back to the start of a hardware loop. Each cycle in which the strobe is high, it samples an instruction word, the address of that instruction, the loop-start address register and a four-bit condition-flag vector. It then classifies the word as a move-and-loop opcode, as a reserved variant of that opcode, or as an unrelated instruction.

For a recognised opcode, the unit evaluates the condition selected by the low nibble against the flags. When the loop is taken, the next fetch address is the loop-start register minus four; otherwise it is the instruction address plus four. The unit also signals that a load with post-increment must be carried out. That memory access and the register updates belong to other units.

All results are registered and appear one cycle after the strobe. The outputs keep their values until the next strobe.

Top module: `mvloop_branch_unit`

## Requirements
- R1: An instruction word is a move-and-loop opcode when bits 31:16 equal 0xF7E0 and bits 3:0 lie in 0x0..0xA; bits 15:4 are ignored. In that case `match_o` and `load_inc_o` are 1 in the cycle after the strobe.
- R2: Flag encoding in `flags_i`: bit 0 = Z, bit 1 = V, bit 2 = C, bit 3 = N. Signed conditions by nibble: 0x0 taken when N^V; 0x1 when !(Z|(N^V)); 0x2 when !(N^V); 0x3 when Z|(N^V).
- R3: Unsigned conditions: 0x4 taken when C; 0x5 when !(C|Z); 0x6 when !C; 0x7 when C|Z.
- R4: Condition 0x8 is taken when Z. Condition 0x9 is taken when !Z. Condition 0xA is always taken, whatever the flags.
- R5: For a matching opcode with the condition taken, `next_pc_o` = `loop_addr_i` − 4 (modulo 2^32) and `taken_o` = 1.
- R6: For a matching opcode with the condition not taken, `next_pc_o` = `pc_i` + 4 and `taken_o` = 0.
- R7: A word with prefix 0xF7E0 and low nibble 0xB..0xF gives `illegal_o` = 1, `match_o` = 0, `taken_o` = 0, `load_inc_o` = 0 and `next_pc_o` = `pc_i` (unchanged).
- R8: A word without the 0xF7E0 prefix gives `match_o`, `taken_o`, `illegal_o` and `load_inc_o` all 0, and `next_pc_o` = `pc_i` + 4.
- R9: The outputs update only on the clock edge after `valid_i` is 1. With `valid_i` low they hold their values. `out_valid_o` is `valid_i` delayed by one cycle.
- R10: Synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input strobe |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| loop_addr_i | input | 32 | Loop-start address register |
| flags_i | input | 4 | Condition flags {N,C,V,Z} |
| out_valid_o | output | 1 | Result valid |
| match_o | output | 1 | Move-and-loop opcode recognised |
| taken_o | output | 1 | Loop taken |
| illegal_o | output | 1 | Reserved condition nibble |
| load_inc_o | output | 1 | Post-increment load required |
| next_pc_o | output | 32 | Next fetch address |

## Verification
The bench runs every condition nibble against all 16 flag vectors. A design that swaps the N and V bits, confuses C with Z, or inverts one condition gives the wrong `taken_o` for some of those flag vectors. Loop-start values of 0 and 2 check that the subtraction wraps modulo 2^32, so a design that saturates or drops the borrow produces a wrong `next_pc_o`. Nibbles 0xA and 0xB check the boundary between legal and reserved codes. Words that differ by one prefix bit, and words with arbitrary middle bits, catch a design that decodes too few bits or too many. Cycles with the strobe low check that the outputs hold, which catches a unit that updates on every clock.

// File: rtl/mvloop_pkg.sv
package mvloop_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned FLAG_W   = 4;
    localparam int unsigned INSN_LEN = 4;
    localparam logic [15:0] OP_PREFIX = 16'hF7E0;
    localparam logic [3:0]  LAST_COND = 4'hA;

    localparam int unsigned FZ = 0;
    localparam int unsigned FV = 1;
    localparam int unsigned FC = 2;
    localparam int unsigned FN = 3;

    typedef enum logic [1:0] {
        CLS_OTHER   = 2'd0,
        CLS_LOOP    = 2'd1,
        CLS_ILLEGAL = 2'd2
    } insn_class_e;

    typedef struct packed {
        insn_class_e cls;
        logic [3:0]  cond;
    } decode_t;

    function automatic logic cond_true(input logic [3:0] cond, input logic [FLAG_W-1:0] f);
        logic z, c, lt;
        z  = f[FZ];
        c  = f[FC];
        lt = f[FN] ^ f[FV];
        case (cond)
            4'h0:    cond_true = lt;
            4'h1:    cond_true = !(z | lt);
            4'h2:    cond_true = !lt;
            4'h3:    cond_true = z | lt;
            4'h4:    cond_true = c;
            4'h5:    cond_true = !(c | z);
            4'h6:    cond_true = !c;
            4'h7:    cond_true = c | z;
            4'h8:    cond_true = z;
            4'h9:    cond_true = !z;
            4'hA:    cond_true = 1'b1;
            default: cond_true = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mvloop_decode.sv
module mvloop_decode
    import mvloop_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output decode_t           dec
);
    logic prefix_hit;
    assign prefix_hit = (instr[WORD_W-1:WORD_W-16] == OP_PREFIX);

    always_comb begin
        dec.cond = instr[3:0];
        if (!prefix_hit)
            dec.cls = CLS_OTHER;
        else if (instr[3:0] <= LAST_COND)
            dec.cls = CLS_LOOP;
        else
            dec.cls = CLS_ILLEGAL;
    end
endmodule

// File: rtl/mvloop_cond_eval.sv
module mvloop_cond_eval
    import mvloop_pkg::*;
(
    input  decode_t           dec,
    input  logic [FLAG_W-1:0] flags,
    output logic              take
);
    always_comb begin
        take = (dec.cls == CLS_LOOP) && cond_true(dec.cond, flags);
    end
endmodule

// File: rtl/mvloop_branch_unit.sv
module mvloop_branch_unit
    import mvloop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       pc_i,
    input  logic [31:0]       loop_addr_i,
    input  logic [3:0]        flags_i,
    output logic              out_valid_o,
    output logic              match_o,
    output logic              taken_o,
    output logic              illegal_o,
    output logic              load_inc_o,
    output logic [31:0]       next_pc_o
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(INSN_LEN);

    decode_t dec;
    logic    take;
    logic [WORD_W-1:0] npc;

    mvloop_decode u_dec (.instr(instr_i), .dec(dec));
    mvloop_cond_eval u_eval (.dec(dec), .flags(flags_i), .take(take));

    always_comb begin
        if (dec.cls == CLS_ILLEGAL)
            npc = pc_i;
        else if (take)
            npc = loop_addr_i - STEP;
        else
            npc = pc_i + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            match_o     <= 1'b0;
            taken_o     <= 1'b0;
            illegal_o   <= 1'b0;
            load_inc_o  <= 1'b0;
            next_pc_o   <= '0;
        end else begin
            out_valid_o <= valid_i;
            if (valid_i) begin
                match_o    <= (dec.cls == CLS_LOOP);
                taken_o    <= take;
                illegal_o  <= (dec.cls == CLS_ILLEGAL);
                load_inc_o <= (dec.cls == CLS_LOOP);
                next_pc_o  <= npc;
            end
        end
    end

    // R7: match and illegal never both set
    a_r7_excl: assert property (@(posedge clk) disable iff (rst)
        !(match_o && illegal_o));
    // R5: taken implies a recognised opcode
    a_r5_taken_match: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> match_o);
    // R5: taken result points before the loop start
    a_r5_target: assert property (@(posedge clk) disable iff (rst)
        valid_i && (instr_i[31:16] == 16'hF7E0) && (instr_i[3:0] == 4'hA)
        |=> taken_o && next_pc_o == $past(loop_addr_i) - 32'd4);
    // R9: outputs hold without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(next_pc_o) && $stable(match_o) && $stable(taken_o));
    // R8: foreign word gives pc+4 and no flags
    a_r8_other: assert property (@(posedge clk) disable iff (rst)
        valid_i && (instr_i[31:16] != 16'hF7E0)
        |=> !match_o && !illegal_o && next_pc_o == $past(pc_i) + 32'd4);
    // R1: load request tracks match
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        load_inc_o == match_o);
endmodule

// File: tb/sim_mvloop_branch_unit.sv
`timescale 1ns/1ps
module sim_mvloop_branch_unit;
    logic clk = 1'b0;
    logic rst;
    logic valid_i;
    logic [31:0] instr_i, pc_i, loop_addr_i;
    logic [3:0] flags_i;
    logic out_valid_o, match_o, taken_o, illegal_o, load_inc_o;
    logic [31:0] next_pc_o;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mvloop_branch_unit u0 (.*);

    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent reference of the condition table (flags {N,C,V,Z})
    function automatic logic ref_take(input logic [3:0] c, input logic [3:0] f);
        logic z, v, cy, n;
        {n, cy, v, z} = f;
        case (c)
            0: return n != v;
            1: return !z && (n == v);
            2: return n == v;
            3: return z || (n != v);
            4: return cy;
            5: return !cy && !z;
            6: return !cy;
            7: return cy || z;
            8: return z;
            9: return !z;
            10: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] la, input logic [3:0] f);
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; pc_i = pc; loop_addr_i = la; flags_i = f;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; valid_i = 1'b0; instr_i = 0; pc_i = 0; loop_addr_i = 0; flags_i = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {26'd0, out_valid_o, match_o, taken_o, illegal_o, load_inc_o, 1'b0}, 32'd0);
        chk("R10 reset next_pc", next_pc_o, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_conditions();
        for (int c = 0; c <= 10; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic exp_t;
                string rq;
                exp_t = ref_take(c[3:0], f[3:0]);
                rq = (c < 4) ? "R2" : (c < 8) ? "R3" : "R4";
                issue(32'hF7E0_0000 | 32'(c) | 32'(f << 8), 32'h1000_0000 + 32'(f*16), 32'h2000_0100, f[3:0]);
                chk({rq, " taken"}, {31'd0, taken_o}, {31'd0, exp_t});
                chk("R1 match", {30'd0, match_o, load_inc_o}, 32'd3);
                chk(exp_t ? "R5 target" : "R6 fallthrough", next_pc_o,
                    exp_t ? 32'h2000_00FC : 32'h1000_0004 + 32'(f*16));
            end
        end
    endtask

    task automatic t_wrap();
        issue(32'hF7E0_ABCA, 32'h10, 32'h0, 4'h0);
        chk("R5 wrap 0", next_pc_o, 32'hFFFF_FFFC);
        issue(32'hF7E0_000A, 32'h10, 32'h2, 4'h0);
        chk("R5 wrap 2", next_pc_o, 32'hFFFF_FFFE);
        issue(32'hF7E0_0009, 32'hFFFF_FFFC, 32'h500, 4'h1);
        chk("R6 pc wrap", next_pc_o, 32'h0);
    endtask

    task automatic t_illegal();
        for (int c = 11; c < 16; c++) begin
            issue(32'hF7E0_0000 | 32'(c), 32'h4444_0000, 32'h100, 4'hF);
            chk("R7 flags", {28'd0, match_o, taken_o, illegal_o, load_inc_o}, 32'b0010);
            chk("R7 pc held", next_pc_o, 32'h4444_0000);
        end
    endtask

    task automatic t_other();
        issue(32'hF7E1_000A, 32'h300, 32'h900, 4'h0);
        chk("R8 prefix bit", {28'd0, match_o, taken_o, illegal_o, load_inc_o}, 32'd0);
        chk("R8 pc", next_pc_o, 32'h304);
        issue(32'h77E0_0000, 32'h400, 32'h900, 4'h1);
        chk("R8 top bit", {28'd0, match_o, taken_o, illegal_o, load_inc_o}, 32'd0);
        chk("R8 pc2", next_pc_o, 32'h404);
    endtask

    task automatic t_hold();
        issue(32'hF7E0_000A, 32'h0, 32'h800, 4'h0);
        @(negedge clk);
        chk("R9 out_valid low", {31'd0, out_valid_o}, 32'd0);
        instr_i = 32'h0; pc_i = 32'h1234;
        repeat (3) @(negedge clk);
        chk("R9 hold pc", next_pc_o, 32'h7FC);
        chk("R9 hold taken", {31'd0, taken_o}, 32'd1);
        @(negedge clk);
        valid_i = 1'b1; instr_i = 32'h0; pc_i = 32'h50;
        @(negedge clk);
        chk("R9 out_valid high", {31'd0, out_valid_o}, 32'd1);
        chk("R9 update", next_pc_o, 32'h54);
        valid_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_conditions();
        t_wrap();
        t_illegal();
        t_other();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule